// File: doc/BRIEF.md
# Time-Multiplexed Running Count Link

This block carries a wide free-running count from one place on a chip to another over a bus half the count's width. The sending side looks at count bit 0. On even counts it places the lower word's upper bits on the bus. On odd counts it places the upper word's bits there. Bit 0 always travels as itself, so the receiver can tell which half it is seeing. The top count bit is dropped. The receiving side rebuilds a count one bit narrower than the source.

The receiver also holds one armed timer target. It compares only the upper bits of the target's low word, and only on even cycles, when those count bits are on the bus. The target's own bit 0 then decides the pulse timing. An even target pulses straight away. An odd target is held one clock so that its pulse lines up with the odd count. The pulse is aligned with the rebuilt count, so it is high in the same cycle that the rebuilt low word equals the target. Arming is one-shot.

Top module: `mux_count_link`

## Requirements
- R1: Bus bit 0 equals count bit 0 in every cycle.
- R2: With count bit 0 low, bus bits W-1..1 carry count bits W-1..1. With count bit 0 high, they carry count bits 2W-2..W.
- R3: For a count that rises by one each clock, the rebuilt count equals bits 2W-2..0 of the count sampled at the previous clock edge. This holds from the second sample after reset onward, including across wraps of the low word and of the whole rebuilt width.
- R4: While reset is low, the rebuilt count reads zero, the event output is low and no target is armed.
- R5: A high arm input at a clock edge loads the target and arms it. The new target is first compared on the next even sample after that edge, so a match that needed an earlier even sample is missed until the low word comes round again.
- R6: An armed even target produces its event in the cycle where the rebuilt low word equals the target.
- R7: An armed odd target produces its event in the cycle where the rebuilt low word equals the target, which is one clock after its even compare.
- R8: The event is a single-cycle pulse that disarms the target, so later passes of the same low word give no pulse until the next arm.
- R9: If an arm and a match of the previous target fall on the same edge, the previous target still pulses at its correct cycle, and the new target is left armed.
- R10: Count bit 2W-1 has no effect on the bus or on the rebuilt count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 2W | Running count to be sent |
| bus_o | output | W | Multiplexed count bus |
| arm_i | input | 1 | Load the target and arm it |
| tgt_i | input | W | Event target, compared against the low word |
| time_o | output | 2W-1 | Rebuilt count, one clock behind the sample |
| evt_o | output | 1 | Single-cycle timer event pulse |

## Verification
Two functions can fall on the same edge: loading a fresh target and the compare hit of the target already armed. The sweep re-arms at one fixed low-word position in every low-word period, using a target that differs from period to period. Some targets lie at or just after that arm position. These miss their own period and hit in the next one, exactly on the edge where the following arm arrives. In those cycles the bench expects the old pulse at its even or odd position and a later pulse for the new target. The checks are tagged so that these coincident cases report under their own requirement.

// File: rtl/mux_count_link.sv
module mux_count_link #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*W-1:0] cnt_i,
  output logic [W-1:0]   bus_o,
  input  logic           arm_i,
  input  logic [W-1:0]   tgt_i,
  output logic [2*W-2:0] time_o,
  output logic           evt_o
);
  localparam int H = W - 1;

  assign bus_o = cnt_i[0] ? {cnt_i[2*W-2:W], 1'b1} : {cnt_i[W-1:1], 1'b0};

  logic         odd;
  logic [H-1:0] lo_q, hi_q, lo_nx, hi_nx;
  logic         lsb_q;

  assign odd   = bus_o[0];
  assign lo_nx = odd ? lo_q : bus_o[W-1:1];
  assign hi_nx = odd ? bus_o[W-1:1]
               : ((bus_o[W-1:1] == '0) ? hi_q + H'(1) : hi_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      lsb_q <= 1'b0;
    end else begin
      lo_q  <= lo_nx;
      hi_q  <= hi_nx;
      lsb_q <= odd;
    end

  assign time_o = {hi_q, lo_q, lsb_q};

  logic [W-1:0] tgt_q;
  logic         armed_q, pend_q, evt_q, hit;

  assign hit = armed_q & ~odd & (bus_o[W-1:1] == tgt_q[W-1:1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tgt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      pend_q <= hit & tgt_q[0];
      evt_q  <= (hit & ~tgt_q[0]) | pend_q;
      if (arm_i) begin
        tgt_q   <= tgt_i;
        armed_q <= 1'b1;
      end else if (hit) begin
        armed_q <= 1'b0;
      end
    end

  assign evt_o = evt_q;
endmodule

// File: rtl/mux_count_link_props.sv
module mux_count_link_props #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*W-1:0] cnt_i,
  input logic [W-1:0]   bus_o,
  input logic           arm_i,
  input logic [W-1:0]   tgt_i,
  input logic [2*W-2:0] time_o,
  input logic           evt_o
);
  localparam int CW = 2 * W;
  localparam logic [CW-1:0] ONE = 1;

  logic [CW-1:0] prev;
  logic          pv, run_ok;
  logic [W-1:0]  t_cur, t_old;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev   <= '0;
      pv     <= 1'b0;
      run_ok <= 1'b0;
      t_cur  <= '0;
      t_old  <= '0;
    end else begin
      pv     <= 1'b1;
      prev   <= cnt_i;
      run_ok <= pv && (cnt_i == prev + ONE);
      if (arm_i) begin
        t_old <= t_cur;
        t_cur <= tgt_i;
      end
    end

  assert_reset_state_R4: assert property (@(posedge clk)
    !rst_n |=> (time_o == '0 && !evt_o));

  assert_even_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !$past(bus_o[0]) |-> time_o[W-1:0] == $past(bus_o));

  assert_odd_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(bus_o[0]) |-> (time_o[CW-2:W] == $past(bus_o[W-1:1]) && time_o[0]));

  assert_rebuild_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok |-> time_o == $past(cnt_i[CW-2:0]));

  assert_event_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok && evt_o |-> (time_o[W-1:0] == t_cur || time_o[W-1:0] == t_old));
endmodule

bind mux_count_link mux_count_link_props #(.W(W)) u_props (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .bus_o(bus_o), .arm_i(arm_i),
  .tgt_i(tgt_i), .time_o(time_o), .evt_o(evt_o)
);

// File: tb/test_mux_count_link.sv
module test_mux_count_link;
  localparam int W = 8;
  localparam int CW = 2 * W;
  localparam int CLK_P = 10;
  localparam int NCYC = 66200;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cnt;
  logic [W-1:0]  bus;
  logic          arm;
  logic [W-1:0]  tgt;
  logic [CW-2:0] tim;
  logic          evt;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mux_count_link #(.W(W)) i_mux_count_link (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .bus_o(bus), .arm_i(arm),
    .tgt_i(tgt), .time_o(tim), .evt_o(evt)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic          marmed, mpend, mexp, nxp, coinc, recent;
  logic [W-1:0]  mt;
  logic [CW-1:0] prev;
  logic [W-1:0]  ebus;

  initial begin
    rst_n = 1'b0; cnt = '0; arm = 1'b0; tgt = '0;
    marmed = 0; mpend = 0; mexp = 0; mt = '0; prev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 time", 64'(tim), 64'd0);
    chk("R4 evt", 64'(evt), 64'd0);
    rst_n = 1'b1;
    for (int n = 0; n < NCYC; n++) begin
      #1;
      ebus = cnt[0] ? {cnt[CW-2:W], 1'b1} : {cnt[W-1:1], 1'b0};
      chk("R1 bus lsb", 64'(bus[0]), 64'(cnt[0]));
      chk("R2 bus word", 64'(bus), 64'(ebus));
      mexp = mpend; nxp = 0; coinc = 0;
      if (marmed && !cnt[0] && cnt[W-1:1] == mt[W-1:1]) begin
        if (mt[0]) nxp = 1; else mexp = 1;
        marmed = 0;
        coinc = arm;
      end
      recent = arm;
      if (arm) begin marmed = 1; mt = tgt; end
      mpend = nxp;
      prev = cnt;
      @(negedge clk);
      if (n >= 1) begin
        chk("R3 rebuild", 64'(tim), 64'(prev[CW-2:0]));
        if (prev[CW-1]) chk("R10 top bit", 64'(tim), 64'(prev[CW-2:0]));
      end
      if (coinc)      chk("R9 coincident", 64'(evt), 64'(mexp));
      else if (mexp)  chk(prev[0] ? "R7 odd event" : "R6 even event", 64'(evt), 64'd1);
      else if (recent) chk("R5 arm", 64'(evt), 64'd0);
      else            chk("R8 no pulse", 64'(evt), 64'd0);
      cnt = cnt + 1'b1;
      arm = (cnt[W-1:0] == 8'h10);
      if (arm) tgt = cnt[CW-1:W] * 8'd37 + 8'h23;
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule